// File: doc/BRIEF.md
# Scaled-Radian Phase Accumulator

The block produces the running phase for a tone generator. A signed phase step is supplied on a valid/ready input stream and held. Every time the downstream consumer takes a phase beat, the held step is added to the running phase. The phase is the angle fed to a rotator that turns a fixed vector into a sine and cosine pair. The step therefore sets the tone frequency, and a positive step turns the vector counter-clockwise.

Both the step and the phase are 16-bit signed fixed point with 13 fractional bits, so the code 0x2000 stands for +1.0. In scaled radians, +1.0 stands for +π and -1.0 (0xE000) for -π. The phase is folded back into the range from -1.0 to +1.0 after each addition. The plain two's-complement overflow of the register would only wrap at ±4, which is the wrong angle.

A synchronous clear returns the phase to zero and keeps the held step. The end-of-packet flag that arrives with a step is passed on with every output beat.

Top module: `scaled_phase_accum`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads the following values: phase 0, held step 0, output last 0 and output valid 0.
- R2: `ph_valid` is 1 from the first clock edge after reset is released. `inc_ready` is always 1.
- R3: The phase changes only at an edge where `ph_valid` and `ph_ready` are both 1. At such an edge it becomes the wrapped sum of the old phase and the held step. When `ph_ready` is 0, `ph_data` holds its value.
- R4: If the sum is above +1.0 (signed value above 0x2000), 2.0 (0x4000) is subtracted. A sum of exactly 0x2000 is kept unchanged.
- R5: If the sum is below -1.0 (signed value below -0x2000), 2.0 (0x4000) is added. A sum of exactly -0x2000 is kept unchanged.
- R6: A step whose signed value is above 0x2000 is held as 0x2000. A step whose signed value is below -0x2000 is held as 0xE000.
- R7: A step is taken at any edge where `inc_valid` is 1. It is first used by the next accumulation after that edge; a handshake at the same edge still uses the previous step. When `inc_valid` is 0, the held step is unchanged.
- R8: `clr` high at an edge sets the phase to 0, even if a handshake happens at the same edge. The held step and the last flag are kept.
- R9: `ph_last` equals the `inc_last` value taken with the most recent step.
- R10: The signed value of `ph_data` always lies within -0x2000 to +0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous phase clear |
| inc_data | input | 16 | Signed phase step, 13 fractional bits |
| inc_last | input | 1 | End-of-packet flag that goes with the step |
| inc_valid | input | 1 | Step present |
| inc_ready | output | 1 | Step accepted (always 1) |
| ph_data | output | 16 | Running phase, 13 fractional bits |
| ph_last | output | 1 | Flag taken with the current step |
| ph_valid | output | 1 | Phase beat present |
| ph_ready | input | 1 | Consumer takes the phase beat |

## Verification
The hardest cases to reach are the sums that land exactly on ±1.0 and the sums that cross those limits. With a random step, the phase rarely meets either limit exactly. Directed sequences start from a cleared phase and use chosen steps (0x1800, 0x1000, -0x1800 and clamped extreme steps) so that the sum hits 0x2000 exactly and also crosses both limits. Long random runs then mix gated ready, clear and step changes. These runs check the wrap, the clamp and the one-beat delay of a new step against a model in the bench.

// File: rtl/spa_pkg.sv
// Shared constants of the scaled-radian phase accumulator.
// Assumes: phase words are signed with PHASE_FRAC fractional bits.
package spa_pkg;
    localparam int PHASE_W    = 16;
    localparam int PHASE_FRAC = 13;
endpackage

// File: rtl/spa_inc_hold.sv
// Clamps an incoming phase step to +/-1.0 and holds it with its last flag.
// Assumes: W > FRAC + 1, so that +1.0 can be represented.
module spa_inc_hold #(
    parameter int W    = 16,
    parameter int FRAC = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         in_last,
    output logic [W-1:0] inc_q,
    output logic         last_q
);
    localparam logic signed [W-1:0] POS_ONE = {{(W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};
    localparam logic signed [W-1:0] NEG_ONE = -POS_ONE;

    logic [W-1:0] clamped;

    // Limit the step magnitude to one half turn.
    always_comb begin
        if ($signed(in_data) > POS_ONE)      clamped = POS_ONE;
        else if ($signed(in_data) < NEG_ONE) clamped = NEG_ONE;
        else                                 clamped = in_data;
    end

    // Capture the step on every presented beat; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q  <= '0;
            last_q <= 1'b0;
        end else if (in_valid) begin
            inc_q  <= clamped;
            last_q <= in_last;
        end
    end
endmodule

// File: rtl/spa_wrap_add.sv
// Adds two phases and folds the sum back into [-1.0, +1.0].
// Assumes: both operands already lie within [-1.0, +1.0].
module spa_wrap_add #(
    parameter int W    = 16,
    parameter int FRAC = 13
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam logic signed [W:0] ONE_X = {{(W-FRAC){1'b0}}, 1'b1, {FRAC{1'b0}}};
    localparam logic signed [W:0] TWO_X = ONE_X <<< 1;

    logic signed [W:0] sum;
    logic signed [W:0] folded;

    // Sum with one guard bit, then subtract or add a full turn as needed.
    always_comb begin
        sum = $signed({a[W-1], a}) + $signed({b[W-1], b});
        if (sum > ONE_X)       folded = sum - TWO_X;
        else if (sum < -ONE_X) folded = sum + TWO_X;
        else                   folded = sum;
        y = folded[W-1:0];
    end
endmodule

// File: rtl/scaled_phase_accum.sv
// Streaming phase accumulator: the phase advances by the held step on each
// accepted output beat and is kept within +/-1.0 scaled radians.
// Assumes: synchronous active-low reset; clr only zeroes the phase.
module scaled_phase_accum #(
    parameter int W    = spa_pkg::PHASE_W,
    parameter int FRAC = spa_pkg::PHASE_FRAC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] inc_data,
    input  logic         inc_last,
    input  logic         inc_valid,
    output logic         inc_ready,
    output logic [W-1:0] ph_data,
    output logic         ph_last,
    output logic         ph_valid,
    input  logic         ph_ready
);
    logic [W-1:0] inc_q;
    logic [W-1:0] phase_q;
    logic [W-1:0] phase_next;
    logic         valid_q;

    spa_inc_hold #(.W(W), .FRAC(FRAC)) inc_i (
        .clk(clk), .rst_n(rst_n), .in_valid(inc_valid), .in_data(inc_data),
        .in_last(inc_last), .inc_q(inc_q), .last_q(ph_last)
    );

    spa_wrap_add #(.W(W), .FRAC(FRAC)) add_i (
        .a(phase_q), .b(inc_q), .y(phase_next)
    );

    // Running phase and output valid; clear takes priority over a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b1;
            if (clr)                      phase_q <= '0;
            else if (valid_q && ph_ready) phase_q <= phase_next;
        end
    end

    assign inc_ready = 1'b1;
    assign ph_data   = phase_q;
    assign ph_valid  = valid_q;
endmodule

// File: rtl/scaled_phase_accum_chk.sv
// Property checker for scaled_phase_accum, attached by bind.
module scaled_phase_accum_chk #(
    parameter int W    = 16,
    parameter int FRAC = 13
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         inc_valid,
    input logic         inc_last,
    input logic         inc_ready,
    input logic [W-1:0] ph_data,
    input logic         ph_last,
    input logic         ph_valid,
    input logic         ph_ready
);
    localparam logic signed [W-1:0] ONE = {{(W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

    assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n) inc_ready);
    assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> ph_valid);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(ph_valid && ph_ready)) |=> $stable(ph_data));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n) clr |=> ph_data == '0);
    assert_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inc_valid |=> ph_last == $past(inc_last));
    assert_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(ph_data) <= ONE) && ($signed(ph_data) >= -ONE));
endmodule

bind scaled_phase_accum scaled_phase_accum_chk #(.W(W), .FRAC(FRAC)) chk_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc_valid(inc_valid), .inc_last(inc_last),
    .inc_ready(inc_ready), .ph_data(ph_data), .ph_last(ph_last),
    .ph_valid(ph_valid), .ph_ready(ph_ready)
);

// File: tb/scaled_phase_accum_tb_top.sv
module scaled_phase_accum_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, clr, inc_last, inc_valid, ph_ready;
    logic [15:0] inc_data;
    logic        inc_ready, ph_last, ph_valid;
    logic [15:0] ph_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_phase, m_inc;
    logic        m_last, m_valid;

    always #2 clk = ~clk;

    scaled_phase_accum dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc_data(inc_data), .inc_last(inc_last),
        .inc_valid(inc_valid), .inc_ready(inc_ready), .ph_data(ph_data), .ph_last(ph_last),
        .ph_valid(ph_valid), .ph_ready(ph_ready)
    );

    function automatic logic [15:0] clamp_f(input logic [15:0] v);
        int s = int'($signed(v));
        if (s > 8192) s = 8192;
        else if (s < -8192) s = -8192;
        return 16'(s);
    endfunction

    function automatic logic [15:0] wrap_f(input logic [15:0] p, input logic [15:0] i);
        int s = int'($signed(p)) + int'($signed(i));
        if (s > 8192) s -= 16384;
        else if (s < -8192) s += 16384;
        return 16'(s);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " data"}, ph_data, m_phase);
        check({"R2 valid/", tag}, 16'(ph_valid), 16'(m_valid));
        check({"R9 last/", tag}, 16'(ph_last), 16'(m_last));
        check("R2 ready", 16'(inc_ready), 16'h1);
    endtask

    // Drive at negedge, update the model at the edge, compare at the next negedge.
    task automatic step(input bit iv, input logic [15:0] id, input bit il,
                        input bit rdy, input bit cl, input string tag);
        inc_valid = iv; inc_data = id; inc_last = il; ph_ready = rdy; clr = cl;
        @(posedge clk);
        if (cl) m_phase = '0;
        else if (m_valid && rdy) m_phase = wrap_f(m_phase, m_inc);
        if (iv) begin m_inc = clamp_f(id); m_last = il; end
        m_valid = 1'b1;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clr = 1'b0; inc_valid = 1'b1; inc_data = 16'h0400;
        inc_last = 1'b1; ph_ready = 1'b1;
        m_phase = '0; m_inc = '0; m_last = 1'b0; m_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset phase", ph_data, 16'h0);
        check("R1 reset valid", 16'(ph_valid), 16'h0);
        check("R1 reset last", 16'(ph_last), 16'h0);
        rst_n = 1'b1;
        // R1: the step driven during reset was not kept, so the phase stays 0.
        step(0, 16'h0, 0, 1, 0, "R1 step zero after reset");
        step(0, 16'h0, 0, 1, 0, "R1 step zero after reset");
        // R7: a new step is first used by the following accumulation.
        step(1, 16'h0100, 1, 1, 0, "R7 new step");
        step(0, 16'h0, 0, 1, 0, "R3 advance");
        step(0, 16'h0, 0, 1, 0, "R3 advance");
        step(0, 16'h0, 0, 0, 0, "R3 hold ready low");
        step(0, 16'h0, 0, 0, 0, "R3 hold ready low");
        // R8: the clear wins over the handshake and the step is kept.
        step(0, 16'h0, 0, 1, 1, "R8 clear with handshake");
        step(0, 16'h0, 0, 1, 0, "R8 step kept");
        step(0, 16'h0, 0, 1, 1, "R8 clear");
        // R4: wrap high and the exact +1.0 boundary.
        step(1, 16'h1800, 0, 0, 0, "R4 load");
        step(0, 16'h0, 0, 1, 0, "R4 0x1800");
        step(0, 16'h0, 0, 1, 0, "R4 wrap above one");
        step(1, 16'h1000, 0, 1, 1, "R4 clear");
        step(0, 16'h0, 0, 1, 0, "R4 0x1000");
        step(0, 16'h0, 0, 1, 0, "R4 exact one kept");
        // R5: wrap low and the exact -1.0 boundary.
        step(1, 16'hE800, 0, 1, 1, "R5 clear");
        step(0, 16'h0, 0, 1, 0, "R5 -0x1800");
        step(0, 16'h0, 0, 1, 0, "R5 wrap below minus one");
        step(1, 16'hF000, 0, 1, 1, "R5 clear");
        step(0, 16'h0, 0, 1, 0, "R5 -0x1000");
        step(0, 16'h0, 0, 1, 0, "R5 exact minus one kept");
        // R6: the extreme steps are clamped to +/-1.0.
        step(1, 16'h7FFF, 1, 1, 1, "R6 clear");
        step(0, 16'h0, 0, 1, 0, "R6 positive clamp");
        step(0, 16'h0, 0, 1, 0, "R6 positive clamp");
        step(1, 16'h8000, 0, 1, 1, "R6 clear");
        step(0, 16'h0, 0, 1, 0, "R6 negative clamp");
        step(1, 16'h2001, 1, 1, 0, "R6 just above one");
        step(0, 16'h0, 0, 1, 0, "R6 just above one");
        // Random mix: R3 R4 R5 R6 R7 R8 R9 R10.
        void'($urandom(32'd1234));
        for (int k = 0; k < 2000; k++) begin
            bit iv  = ($urandom % 4) == 0;
            bit rdy = ($urandom % 4) != 0;
            bit cl  = ($urandom % 50) == 0;
            logic [15:0] d = (($urandom % 3) == 0) ? 16'($urandom) : 16'(int'($urandom % 16385) - 8192);
            step(iv, d, 1'($urandom), rdy, cl, "R10 random");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule